// File: doc/BRIEF.md
# Multi-Stage Conversion Sequencer

This block drives a capacitance front end through an ordered list of conversion stages. A run always opens at stage 0 and climbs one stage at a time up to a programmed final index. For each stage it presents that stage's input-routing word to the analog switch matrix. It then starts the averaging converter (decimator) and waits for its done strobe. The returned result is filed into the result slot that belongs to the stage, tagged with the stage's calibration-enable bit.

Software programs the block through a small write port that holds twelve routing words, the final-stage index and a calibration-enable mask. Results come back through a combinational read port indexed by stage. A start request launches a run. With the continuous-mode input high, the block wraps from the final stage back to stage 0 with no idle gap. With it low, the block stops after one pass. In both modes a one-cycle completion pulse marks the end of each pass.

Top module: `conv_stage_sequencer`

## Requirements
- R1: A start request is taken only while the block is idle and always begins at stage 0. A request made while a run is in progress is ignored.
- R2: Stages run in ascending order from 0 up to the latched final index L, so a pass covers L+1 stages. A programmed index above 11 acts as 11.
- R3: `route_sel` carries the routing word of the current stage. It is loaded on the clock edge that opens the stage, is present for at least one full cycle before `conv_start`, and holds steady until `conv_done` is accepted.
- R4: `conv_start` is a one-cycle pulse, issued once per stage. It is seen in the second cycle after the edge that accepted the start request or the previous stage's done.
- R5: When `conv_done` is accepted, `conv_result` is written into the slot of the current stage. The slot's calibration flag is set to bit s of the mask at that moment. Slots of stages that do not run keep their contents.
- R6: In single mode the block returns to idle after the final stage. `seq_done` is high for exactly the one cycle that follows the edge accepting the final done.
- R7: In continuous mode the block restarts at stage 0 with the same two-cycle spacing as between stages, and `seq_done` pulses at the end of every pass.
- R8: The final-stage index is sampled only when a pass begins at stage 0. A write made during a pass first affects the next pass.
- R9: `conv_done` is ignored unless a conversion is outstanding. It then changes no slot and raises no `seq_done`.
- R10: After reset, `conv_start`, `seq_done` and `route_sel` are 0, and every result slot and calibration flag reads 0.
- R11: Write map: addresses 0 to 11 hold the routing word of that stage (data bits 13:0). Address 12 holds the final index (bits 3:0). Address 13 holds the calibration mask, with bit i belonging to stage i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Request to begin a pass at stage 0 |
| cont_mode | input | 1 | 1: wrap after the final stage, 0: stop |
| reg_wr | input | 1 | Write strobe for the configuration port |
| reg_addr | input | 4 | Configuration address |
| reg_wdata | input | 14 | Configuration write data |
| conv_start | output | 1 | Start pulse to the decimator |
| conv_done | input | 1 | Decimator result-ready strobe |
| conv_result | input | 16 | Decimator result |
| route_sel | output | 14 | Routing word to the switch matrix |
| seq_done | output | 1 | One-cycle end-of-pass pulse |
| rd_idx | input | 4 | Result slot to read |
| rd_result | output | 16 | Stored result of the selected slot |
| rd_cal | output | 1 | Calibration flag of the selected slot |

## Verification
The routing word appears on the edge after the accepted start or done. `conv_start` shows up at the second falling edge after that edge, and `seq_done` is high at the first falling edge after it. The bench therefore counts falling edges from each stimulus and requires the start pulse at exactly the second one, in the middle of passes and across wraps alike. Every done is driven at least one cycle after the start is seen, so that it lands in the waiting state. The read port is combinational, so each slot is compared a moment after its index is set.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_KICK  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs #(
  parameter int NUM_STAGES = 12,
  parameter int NUM_INPUTS = 14,
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [NUM_INPUTS-1:0] route_tbl [NUM_STAGES],
  output logic [IDX_W-1:0]      last_raw,
  output logic [NUM_STAGES-1:0] cal_mask
);
  localparam int ADDR_LAST = NUM_STAGES;
  localparam int ADDR_CAL  = NUM_STAGES + 1;

  logic ld_last, ld_cal;
  assign ld_last = wr_en && (wr_addr == ADDR_W'(ADDR_LAST));
  assign ld_cal  = wr_en && (wr_addr == ADDR_W'(ADDR_CAL));

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_route
    logic                  ld;
    logic [NUM_INPUTS-1:0] word_q;
    assign ld = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (ld) begin
        word_q <= wr_data[NUM_INPUTS-1:0];
      end
    end
    assign route_tbl[g] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_raw <= '0;
    end else if (ld_last) begin
      last_raw <= wr_data[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_mask <= '0;
    end else if (ld_cal) begin
      cal_mask <= wr_data[NUM_STAGES-1:0];
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_STAGES = 12,
  parameter int NUM_INPUTS = 14,
  parameter int IDX_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  input  logic                  cont_mode,
  input  logic [IDX_W-1:0]      last_raw,
  input  logic [NUM_INPUTS-1:0] route_tbl [NUM_STAGES],
  input  logic                  conv_done,
  output logic                  conv_start,
  output logic [NUM_INPUTS-1:0] route_sel,
  output logic                  seq_done,
  output logic                  slot_we,
  output logic [IDX_W-1:0]      slot_idx
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_STAGES - 1);

  seq_state_e            state_q, state_d;
  logic [IDX_W-1:0]      stage_q, stage_d;
  logic [IDX_W-1:0]      last_q, last_d;
  logic [NUM_INPUTS-1:0] route_q, route_d;
  logic                  route_ld;
  logic                  done_q, done_d;
  logic [IDX_W-1:0]      last_clamped;
  logic                  done_hit;
  logic                  at_last;
  logic [IDX_W-1:0]      next_idx;

  // the final index is limited to the highest stage that exists
  assign last_clamped = (int'(last_raw) > NUM_STAGES - 1) ? TOP_IDX : last_raw;
  assign done_hit     = (state_q == ST_WAIT) && conv_done;
  assign at_last      = (stage_q == last_q);
  assign next_idx     = at_last ? '0 : stage_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    stage_d  = stage_q;
    last_d   = last_q;
    route_d  = route_q;
    route_ld = 1'b0;
    done_d   = done_hit && at_last;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          stage_d  = '0;
          last_d   = last_clamped;
          route_d  = route_tbl[0];
          route_ld = 1'b1;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: state_d = ST_KICK;
      ST_KICK:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_done) begin
          if (at_last && !cont_mode) begin
            state_d = ST_IDLE;
          end else begin
            stage_d  = next_idx;
            route_d  = route_tbl[next_idx];
            route_ld = 1'b1;
            state_d  = ST_SETUP;
            if (at_last) begin
              last_d = last_clamped;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
    end else if (route_ld) begin
      route_q <= route_d;
    end
  end

  assign conv_start = (state_q == ST_KICK);
  assign route_sel  = route_q;
  assign seq_done   = done_q;
  assign slot_we    = done_hit;
  assign slot_idx   = stage_q;
endmodule

// File: rtl/seq_result_bank.sv
module seq_result_bank #(
  parameter int NUM_STAGES = 12,
  parameter int RESULT_W   = 16,
  parameter int IDX_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [RESULT_W-1:0]   wr_data,
  input  logic [NUM_STAGES-1:0] cal_mask,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [RESULT_W-1:0]   rd_data,
  output logic                  rd_cal
);
  logic [RESULT_W-1:0] res_arr [NUM_STAGES];
  logic                cal_arr [NUM_STAGES];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_slot
    logic                hit;
    logic [RESULT_W-1:0] res_q;
    logic                cal_q;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        cal_q <= 1'b0;
      end else if (hit) begin
        res_q <= wr_data;
        cal_q <= cal_mask[g];
      end
    end
    assign res_arr[g] = res_q;
    assign cal_arr[g] = cal_q;
  end

  always_comb begin
    rd_data = '0;
    rd_cal  = 1'b0;
    if (int'(rd_idx) < NUM_STAGES) begin
      rd_data = res_arr[rd_idx];
      rd_cal  = cal_arr[rd_idx];
    end
  end
endmodule

// File: rtl/conv_stage_sequencer.sv
module conv_stage_sequencer #(
  parameter  int NUM_STAGES = 12,
  parameter  int NUM_INPUTS = 14,
  parameter  int RESULT_W   = 16,
  localparam int IDX_W      = $clog2(NUM_STAGES),
  localparam int ADDR_W     = $clog2(NUM_STAGES + 2),
  localparam int DATA_W     = seq_pkg::max_int(NUM_INPUTS, NUM_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  input  logic                  cont_mode,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic                  conv_start,
  input  logic                  conv_done,
  input  logic [RESULT_W-1:0]   conv_result,
  output logic [NUM_INPUTS-1:0] route_sel,
  output logic                  seq_done,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [RESULT_W-1:0]   rd_result,
  output logic                  rd_cal
);
  logic [1:0]            rst_pipe;
  logic                  rst_sync_n;
  logic [NUM_INPUTS-1:0] route_tbl [NUM_STAGES];
  logic [IDX_W-1:0]      last_raw;
  logic [NUM_STAGES-1:0] cal_mask;
  logic                  slot_we;
  logic [IDX_W-1:0]      slot_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  seq_cfg_regs #(
    .NUM_STAGES(NUM_STAGES), .NUM_INPUTS(NUM_INPUTS),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .route_tbl(route_tbl), .last_raw(last_raw), .cal_mask(cal_mask)
  );

  seq_ctrl #(
    .NUM_STAGES(NUM_STAGES), .NUM_INPUTS(NUM_INPUTS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .start_req(start_req), .cont_mode(cont_mode),
    .last_raw(last_raw), .route_tbl(route_tbl),
    .conv_done(conv_done), .conv_start(conv_start),
    .route_sel(route_sel), .seq_done(seq_done),
    .slot_we(slot_we), .slot_idx(slot_idx)
  );

  seq_result_bank #(
    .NUM_STAGES(NUM_STAGES), .RESULT_W(RESULT_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(slot_we), .wr_idx(slot_idx), .wr_data(conv_result),
    .cal_mask(cal_mask), .rd_idx(rd_idx),
    .rd_data(rd_result), .rd_cal(rd_cal)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int NUM_INPUTS = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  conv_start,
  input logic                  conv_done,
  input logic [NUM_INPUTS-1:0] route_sel,
  input logic                  seq_done
);
  logic wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
    end else if (conv_start) begin
      wait_q <= 1'b1;
    end else if (conv_done) begin
      wait_q <= 1'b0;
    end
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_no_start_while_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> !conv_start);

  assert_route_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $stable(route_sel));

  assert_route_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !conv_done) |=> $stable(route_sel));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_done_follows_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(conv_done));
endmodule

bind conv_stage_sequencer seq_checker #(.NUM_INPUTS(NUM_INPUTS)) u_seq_checker (
  .clk(clk), .rst_n(rst_sync_n), .conv_start(conv_start),
  .conv_done(conv_done), .route_sel(route_sel), .seq_done(seq_done)
);

// File: tb/conv_stage_sequencer_test.sv
module conv_stage_sequencer_test;
  localparam int NS = 12;

  logic        clk;
  logic        rst_n;
  logic        start_req, cont_mode, reg_wr, conv_done;
  logic [3:0]  reg_addr;
  logic [13:0] reg_wdata;
  logic [15:0] conv_result;
  logic [3:0]  rd_idx;
  logic        conv_start, seq_done, rd_cal;
  logic [13:0] route_sel;
  logic [15:0] rd_result;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [15:0] exp_res [NS];
  logic        exp_cal [NS];
  logic [13:0] route_m [NS];
  logic [11:0] mask_m;

  conv_stage_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cont_mode(cont_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .route_sel(route_sel), .seq_done(seq_done),
    .rd_idx(rd_idx), .rd_result(rd_result), .rd_cal(rd_cal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  function automatic logic [13:0] route_val(input int s, input int salt);
    return 14'((s + 1) * 1093 + salt * 77);
  endfunction

  function automatic logic [15:0] res_val(input int s, input int salt);
    return 16'(salt * 4099 + s * 313 + 7);
  endfunction

  // R11: address 0..11 routing words, 12 final index, 13 calibration mask
  task automatic wr_reg(input int addr, input logic [13:0] data);
    reg_wr = 1'b1; reg_addr = 4'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic program_all(input int salt, input int lastp);
    for (int i = 0; i < NS; i++) begin
      route_m[i] = route_val(i, salt);
      wr_reg(i, route_m[i]);
    end
    mask_m = 12'((salt * 12'h5a3) ^ 12'ha5a);
    wr_reg(13, {2'b00, mask_m});
    wr_reg(12, 14'(lastp));
  endtask

  // action: 0 none, 1 start request while busy, 2 final index -> 0, 3 leave continuous mode
  task automatic do_stage(input int s, input int last_eff, input int delay,
                          input int salt, input int action);
    int gap;
    logic [13:0] prev;
    gap = 0;
    prev = route_sel;
    do begin
      prev = route_sel;
      @(negedge clk);
      gap++;
    end while (!conv_start && gap < 50);
    chk($sformatf("R4 start spacing stage %0d", s), gap, 1);
    chk($sformatf("R2 R3 route at start stage %0d", s), route_sel, route_m[s]);
    chk($sformatf("R3 route one cycle early stage %0d", s), prev, route_m[s]);
    for (int k = 0; k < delay; k++) begin
      if (k == 0) begin
        case (action)
          1: start_req = 1'b1;
          2: begin reg_wr = 1'b1; reg_addr = 4'd12; reg_wdata = 14'd0; end
          3: cont_mode = 1'b0;
          default: ;
        endcase
      end
      @(negedge clk);
      start_req = 1'b0;
      reg_wr = 1'b0;
      if (k == 0) chk($sformatf("R4 single start pulse stage %0d", s), conv_start, 0);
    end
    conv_done = 1'b1;
    conv_result = res_val(s, salt);
    @(negedge clk);
    conv_done = 1'b0;
    exp_res[s] = res_val(s, salt);
    exp_cal[s] = mask_m[s];
    chk($sformatf("R6 R7 seq_done stage %0d", s), seq_done, (s == last_eff));
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < NS; i++) begin
      rd_idx = 4'(i);
      #1;
      chk($sformatf("%s R5 result slot %0d", tag, i), rd_result, exp_res[i]);
      chk($sformatf("%s R5 cal slot %0d", tag, i), rd_cal, exp_cal[i]);
    end
  endtask

  task automatic idle_check(input string tag);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk($sformatf("%s R6 idle no start", tag), conv_start, 0);
      chk($sformatf("%s R6 idle no done", tag), seq_done, 0);
    end
  endtask

  task automatic run_single(input int lastp, input int salt, input bit poke);
    int eff;
    eff = (lastp > NS - 1) ? NS - 1 : lastp;
    program_all(salt, lastp);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    for (int s = 0; s <= eff; s++) begin
      do_stage(s, eff, 1 + (s % 3), salt, (poke && s == 1) ? 1 : 0);
    end
    idle_check($sformatf("R2 last=%0d", lastp));
    readback($sformatf("R2 last=%0d", lastp));
  endtask

  initial begin
    start_req = 0; cont_mode = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    conv_done = 0; conv_result = 0; rd_idx = 0;
    for (int i = 0; i < NS; i++) begin exp_res[i] = '0; exp_cal[i] = 1'b0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 conv_start", conv_start, 0);
    chk("R10 seq_done", seq_done, 0);
    chk("R10 route_sel", route_sel, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    readback("R10");

    // R9: a done strobe with no conversion outstanding changes nothing
    conv_done = 1'b1; conv_result = 16'hbeef;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R9 no seq_done", seq_done, 0);
    idle_check("R9");
    readback("R9");

    // R1 R2 R5 R11: sweep every final index, including values clamped to 11
    for (int lp = 15; lp >= 0; lp--) begin
      run_single(lp, lp + 1, (lp == 5));
    end

    // R7 R8: continuous mode, final index rewritten mid-pass
    program_all(40, 2);
    cont_mode = 1'b1;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    do_stage(0, 2, 1, 40, 0);
    do_stage(1, 2, 2, 40, 2);
    do_stage(2, 2, 1, 40, 0);   // R8: pass still ends at stage 2
    do_stage(0, 0, 2, 41, 0);   // R7: wrap, new final index 0 applies
    do_stage(0, 0, 2, 42, 3);   // leave continuous mode
    idle_check("R7 after continuous");
    readback("R7");

    finish_run();
  end
endmodule